// File: doc/BRIEF.md
# Branch and Condition-Code Unit

This block settles control flow for a small in-order processor. It holds a four-bit one-hot condition code. ALU operations rewrite the code from the ALU result flags. Signed and unsigned compare operations rewrite it from the ordering of two register operands. Other operations leave it alone.

For every decoded operation the block computes the next instruction counter and a taken flag. The branch forms are:

- an unconditional jump;
- a mask-tested conditional branch;
- a decrement-and-branch loop operation, which also returns the decremented count for write-back;
- a call form that saves the current counter as a link value, with the target taken either from the immediate field or from a register operand.

All outputs are registered. The condition code that a conditional branch tests is the registered code, so an ALU or compare operation in one cycle steers a branch presented in the very next cycle.

Top module: `branch_cc_unit`

## Requirements
- R1: On a clock edge with `rst` high, every output becomes zero: `cc_o`, `next_pc_o`, `taken_o`, `link_we_o`, `link_data_o`, `cnt_we_o` and `cnt_data_o`.
- R2: The condition code is encoded with bit0 = zero, bit1 = negative, bit2 = positive and bit3 = overflow. For `op_i`=1 (ALU), the next `cc_o` is 4'b1000 whenever `alu_ovf_i` is high, whatever the other flags. Otherwise it is 4'b0001 if `alu_zero_i` is high, else 4'b0010 if `alu_neg_i` is high, else 4'b0100.
- R3: For `op_i`=2 (signed compare), the next `cc_o` is 4'b0001 if `opa_i`==`opb_i`, 4'b0010 if `opa_i` < `opb_i` as two's-complement values, and 4'b0100 otherwise. A compare never sets bit3.
- R4: For `op_i`=3 (unsigned compare), `cc_o` is set in the same way as for the signed compare, except that the less-than test treats both operands as unsigned.
- R5: For any `op_i` other than 1, 2 or 3, `cc_o` keeps its value.
- R6: For `op_i`=4 (jump), the next `next_pc_o` is `tgt_i` and `taken_o` is 1.
- R7: For `op_i`=5 (conditional branch), `taken_o` is 1 and `next_pc_o` is `tgt_i` exactly when (`mask_i` & `cc_o`) is nonzero, using the code held before this edge. Otherwise `next_pc_o` is `pc_i`+ISZ. An all-ones mask is therefore taken whenever any code bit is set.
- R8: For `op_i`=6 (decrement-and-branch), `cnt_we_o` is 1 and `cnt_data_o` is `opa_i`-1, modulo 2^DW. The branch is taken to `tgt_i` only when that value is nonzero; otherwise `next_pc_o` is `pc_i`+ISZ.
- R9: For `op_i`=7 (call, immediate target), `taken_o` is 1, `next_pc_o` is `tgt_i`, `link_we_o` is 1 and `link_data_o` is `pc_i`.
- R10: For `op_i`=8 (call, register target), `taken_o` is 1, `next_pc_o` is `opb_i`[AW-1:0], `link_we_o` is 1 and `link_data_o` is `pc_i`.
- R11: For `op_i` 0, 1, 2, 3 and 9 to 15, `next_pc_o` is `pc_i`+ISZ and `taken_o`, `link_we_o` and `cnt_we_o` are 0. `link_we_o` is 0 for every operation except 7 and 8, and `cnt_we_o` is 0 for every operation except 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Decoded operation code |
| pc_i | input | AW | Current instruction counter |
| tgt_i | input | AW | Immediate branch target |
| mask_i | input | 4 | Condition mask for the conditional branch |
| opa_i | input | DW | Register operand A (compare left side, loop count) |
| opb_i | input | DW | Register operand B (compare right side, register target) |
| alu_zero_i | input | 1 | ALU result is zero |
| alu_neg_i | input | 1 | ALU result is negative |
| alu_ovf_i | input | 1 | ALU result overflowed |
| cc_o | output | 4 | Registered condition code |
| next_pc_o | output | AW | Next instruction counter |
| taken_o | output | 1 | Branch taken |
| link_we_o | output | 1 | Link register write enable |
| link_data_o | output | AW | Value to write to the link register |
| cnt_we_o | output | 1 | Count register write enable |
| cnt_data_o | output | DW | Decremented count to write back |

## Verification
Two functions meet on one edge in this block. A conditional branch tests the code while, one cycle earlier, an ALU or compare operation has just rewritten it. The bench provokes this by issuing a compare or ALU operation and then, on the next cycle, a conditional branch whose mask selects only the freshly written bit or only a stale one. The random stream produces such pairs continually. A bench model judges each branch against the code that the previous operation should have left, not against the code from before that operation.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_ALU   = 4'd1;
    localparam logic [3:0] OP_CMPS  = 4'd2;
    localparam logic [3:0] OP_CMPU  = 4'd3;
    localparam logic [3:0] OP_JMP   = 4'd4;
    localparam logic [3:0] OP_BCOND = 4'd5;
    localparam logic [3:0] OP_DBNZ  = 4'd6;
    localparam logic [3:0] OP_CALL  = 4'd7;
    localparam logic [3:0] OP_CALLR = 4'd8;

    localparam logic [3:0] CC_ZERO = 4'b0001;
    localparam logic [3:0] CC_NEG  = 4'b0010;
    localparam logic [3:0] CC_POS  = 4'b0100;
    localparam logic [3:0] CC_OVF  = 4'b1000;
endpackage

// File: rtl/bcu_cc_gen.sv
module bcu_cc_gen
    import bcu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          fz,
    input  logic          fn,
    input  logic          fv,
    input  logic [3:0]    cc_cur,
    output logic [3:0]    cc_nxt
);
    logic lt;
    logic eq;

    always_comb begin
        eq = (opa == opb);
        if (op == OP_CMPS) lt = ($signed(opa) < $signed(opb));
        else               lt = (opa < opb);
    end

    always_comb begin
        cc_nxt = cc_cur;
        unique case (op)
            OP_ALU: begin
                if (fv)      cc_nxt = CC_OVF;
                else if (fz) cc_nxt = CC_ZERO;
                else if (fn) cc_nxt = CC_NEG;
                else         cc_nxt = CC_POS;
            end
            OP_CMPS, OP_CMPU: begin
                if (eq)      cc_nxt = CC_ZERO;
                else if (lt) cc_nxt = CC_NEG;
                else         cc_nxt = CC_POS;
            end
            default: cc_nxt = cc_cur;
        endcase
    end
endmodule

// File: rtl/bcu_flow.sv
module bcu_flow
    import bcu_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int ISZ = 4
) (
    input  logic [3:0]    op,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] tgt,
    input  logic [3:0]    mask,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [3:0]    cc_cur,
    output logic [AW-1:0] npc,
    output logic          taken,
    output logic          lwe,
    output logic [AW-1:0] ldat,
    output logic          cwe,
    output logic [DW-1:0] cdat
);
    localparam logic [AW-1:0] STEP = AW'(ISZ);

    logic [AW-1:0] seq_pc;
    logic [DW-1:0] dec;

    always_comb begin
        seq_pc = pc + STEP;
        dec    = opa - DW'(1);
        npc    = seq_pc;
        taken  = 1'b0;
        lwe    = 1'b0;
        ldat   = '0;
        cwe    = 1'b0;
        cdat   = '0;
        unique case (op)
            OP_JMP: begin
                npc   = tgt;
                taken = 1'b1;
            end
            OP_BCOND: begin
                if ((mask & cc_cur) != 4'b0000) begin
                    npc   = tgt;
                    taken = 1'b1;
                end
            end
            OP_DBNZ: begin
                cwe  = 1'b1;
                cdat = dec;
                if (dec != '0) begin
                    npc   = tgt;
                    taken = 1'b1;
                end
            end
            OP_CALL: begin
                npc   = tgt;
                taken = 1'b1;
                lwe   = 1'b1;
                ldat  = pc;
            end
            OP_CALLR: begin
                npc   = opb[AW-1:0];
                taken = 1'b1;
                lwe   = 1'b1;
                ldat  = pc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/branch_cc_unit.sv
module branch_cc_unit #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int ISZ = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    op_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] tgt_i,
    input  logic [3:0]    mask_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic          alu_zero_i,
    input  logic          alu_neg_i,
    input  logic          alu_ovf_i,
    output logic [3:0]    cc_o,
    output logic [AW-1:0] next_pc_o,
    output logic          taken_o,
    output logic          link_we_o,
    output logic [AW-1:0] link_data_o,
    output logic          cnt_we_o,
    output logic [DW-1:0] cnt_data_o
);
    typedef struct packed {
        logic [3:0]    cc;
        logic [AW-1:0] npc;
        logic          taken;
        logic          lwe;
        logic [AW-1:0] ldat;
        logic          cwe;
        logic [DW-1:0] cdat;
    } state_t;

    state_t st_d, st_q;

    logic [3:0]    cc_nxt;
    logic [AW-1:0] f_npc;
    logic          f_taken;
    logic          f_lwe;
    logic [AW-1:0] f_ldat;
    logic          f_cwe;
    logic [DW-1:0] f_cdat;

    bcu_cc_gen #(.DW(DW)) u_cc (
        .op     (op_i),
        .opa    (opa_i),
        .opb    (opb_i),
        .fz     (alu_zero_i),
        .fn     (alu_neg_i),
        .fv     (alu_ovf_i),
        .cc_cur (st_q.cc),
        .cc_nxt (cc_nxt)
    );

    bcu_flow #(.AW(AW), .DW(DW), .ISZ(ISZ)) u_flow (
        .op     (op_i),
        .pc     (pc_i),
        .tgt    (tgt_i),
        .mask   (mask_i),
        .opa    (opa_i),
        .opb    (opb_i),
        .cc_cur (st_q.cc),
        .npc    (f_npc),
        .taken  (f_taken),
        .lwe    (f_lwe),
        .ldat   (f_ldat),
        .cwe    (f_cwe),
        .cdat   (f_cdat)
    );

    always_comb begin
        st_d.cc    = cc_nxt;
        st_d.npc   = f_npc;
        st_d.taken = f_taken;
        st_d.lwe   = f_lwe;
        st_d.ldat  = f_ldat;
        st_d.cwe   = f_cwe;
        st_d.cdat  = f_cdat;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cc_o        = st_q.cc;
    assign next_pc_o   = st_q.npc;
    assign taken_o     = st_q.taken;
    assign link_we_o   = st_q.lwe;
    assign link_data_o = st_q.ldat;
    assign cnt_we_o    = st_q.cwe;
    assign cnt_data_o  = st_q.cdat;
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker
    import bcu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [3:0]    op_i,
    input logic [AW-1:0] tgt_i,
    input logic [DW-1:0] opa_i,
    input logic [3:0]    cc_o,
    input logic [AW-1:0] next_pc_o,
    input logic          taken_o,
    input logic          link_we_o,
    input logic          cnt_we_o,
    input logic [DW-1:0] cnt_data_o
);
    p_onehot_cc_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cc_o));

    p_cc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op_i) != OP_ALU) && ($past(op_i) != OP_CMPS)
         && ($past(op_i) != OP_CMPU)) |-> (cc_o == $past(cc_o)));

    // covers the signed form (R3) and the unsigned form (R4)
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && (($past(op_i) == OP_CMPS) || ($past(op_i) == OP_CMPU)))
        |-> (!cc_o[3] && (cc_o != 4'b0000)));

    p_jump_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op_i) == OP_JMP))
        |-> (taken_o && (next_pc_o == $past(tgt_i))));

    p_count_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op_i) == OP_DBNZ))
        |-> (cnt_we_o && (cnt_data_o == $past(opa_i) - DW'(1))));

    p_link_taken_r9: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> taken_o);

    p_cnt_only_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op_i) != OP_DBNZ)) |-> !cnt_we_o);
endmodule

bind branch_cc_unit bcu_checker #(.AW(AW), .DW(DW)) u_bcu_checker (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .tgt_i      (tgt_i),
    .opa_i      (opa_i),
    .cc_o       (cc_o),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .cnt_we_o   (cnt_we_o),
    .cnt_data_o (cnt_data_o)
);

// File: tb/branch_cc_unit_bench.sv
`timescale 1ns/1ps
module branch_cc_unit_bench;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int ISZ = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    op_i;
    logic [AW-1:0] pc_i, tgt_i;
    logic [3:0]    mask_i;
    logic [DW-1:0] opa_i, opb_i;
    logic          alu_zero_i, alu_neg_i, alu_ovf_i;
    logic [3:0]    cc_o;
    logic [AW-1:0] next_pc_o, link_data_o;
    logic          taken_o, link_we_o, cnt_we_o;
    logic [DW-1:0] cnt_data_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] cc_m = 4'b0000;

    always #5 clk = ~clk;

    branch_cc_unit #(.AW(AW), .DW(DW), .ISZ(ISZ)) u_branch_cc_unit (
        .clk(clk), .rst(rst), .op_i(op_i), .pc_i(pc_i), .tgt_i(tgt_i),
        .mask_i(mask_i), .opa_i(opa_i), .opb_i(opb_i),
        .alu_zero_i(alu_zero_i), .alu_neg_i(alu_neg_i), .alu_ovf_i(alu_ovf_i),
        .cc_o(cc_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
        .link_we_o(link_we_o), .link_data_o(link_data_o),
        .cnt_we_o(cnt_we_o), .cnt_data_o(cnt_data_o)
    );

    function automatic logic [3:0] m_cc(input logic [3:0] op, input logic [DW-1:0] a,
                                        input logic [DW-1:0] b, input logic z, input logic n,
                                        input logic v, input logic [3:0] cur);
        logic lt;
        if (op == 4'd1) return v ? 4'b1000 : z ? 4'b0001 : n ? 4'b0010 : 4'b0100;
        if (op == 4'd2 || op == 4'd3) begin
            lt = (op == 4'd2) ? ($signed(a) < $signed(b)) : (a < b);
            return (a == b) ? 4'b0001 : lt ? 4'b0010 : 4'b0100;
        end
        return cur;
    endfunction

    function automatic string m_req(input logic [3:0] op);
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return "R9";
            4'd8: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                        input logic [3:0] mask, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic z, input logic n, input logic v);
        logic [3:0]    e_cc;
        logic [AW-1:0] e_npc, e_ldat;
        logic          e_tk, e_lwe, e_cwe;
        logic [DW-1:0] e_cdat;
        string         rq;
        @(negedge clk);
        op_i = op; pc_i = pc; tgt_i = tgt; mask_i = mask; opa_i = a; opb_i = b;
        alu_zero_i = z; alu_neg_i = n; alu_ovf_i = v;
        e_cc = m_cc(op, a, b, z, n, v, cc_m);
        e_npc = pc + AW'(ISZ); e_tk = 1'b0; e_lwe = 1'b0; e_ldat = '0;
        e_cwe = 1'b0; e_cdat = '0;
        case (op)
            4'd4: begin e_npc = tgt; e_tk = 1'b1; end
            4'd5: if ((mask & cc_m) != 0) begin e_npc = tgt; e_tk = 1'b1; end
            4'd6: begin
                e_cwe = 1'b1; e_cdat = a - 1;
                if (e_cdat != 0) begin e_npc = tgt; e_tk = 1'b1; end
            end
            4'd7: begin e_npc = tgt; e_tk = 1'b1; e_lwe = 1'b1; e_ldat = pc; end
            4'd8: begin e_npc = b[AW-1:0]; e_tk = 1'b1; e_lwe = 1'b1; e_ldat = pc; end
            default: ;
        endcase
        @(posedge clk);
        #1;
        rq = (op >= 4'd1 && op <= 4'd3) ? m_req(op) : "R5";
        check(rq, "cc", 64'(cc_o), 64'(e_cc));
        rq = m_req(op);
        check(rq, "next_pc", 64'(next_pc_o), 64'(e_npc));
        check(rq, "taken", 64'(taken_o), 64'(e_tk));
        check(rq, "link_we", 64'(link_we_o), 64'(e_lwe));
        if (e_lwe) check(rq, "link_data", 64'(link_data_o), 64'(e_ldat));
        check(rq, "cnt_we", 64'(cnt_we_o), 64'(e_cwe));
        if (e_cwe) check(rq, "cnt_data", 64'(cnt_data_o), 64'(e_cdat));
        cc_m = e_cc;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(1234);
        rst = 1'b1;
        op_i = 0; pc_i = 0; tgt_i = 0; mask_i = 0; opa_i = 0; opb_i = 0;
        alu_zero_i = 0; alu_neg_i = 0; alu_ovf_i = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "cc", 64'(cc_o), 0);
        check("R1", "next_pc", 64'(next_pc_o), 0);
        check("R1", "taken", 64'(taken_o), 0);
        check("R1", "link_we", 64'(link_we_o), 0);
        check("R1", "cnt_we", 64'(cnt_we_o), 0);
        @(negedge clk);
        rst = 1'b0;
        // R7: all-ones mask with cleared code is not taken
        step(4'd5, 32'h100, 32'h800, 4'hF, 0, 0, 0, 0, 0);
        // R2: overflow wins over zero and negative
        step(4'd1, 32'h104, 0, 0, 0, 0, 1, 1, 1);
        // R7: branch right after the update sees the overflow bit only
        step(4'd5, 32'h108, 32'h900, 4'b1000, 0, 0, 0, 0, 0);
        // R3 vs R4: 0x80000000 against 1
        step(4'd2, 32'h10C, 0, 0, 32'h8000_0000, 1, 0, 0, 0);
        step(4'd5, 32'h110, 32'hA00, 4'b0100, 0, 0, 0, 0, 0);
        step(4'd3, 32'h114, 0, 0, 32'h8000_0000, 1, 0, 0, 0);
        step(4'd5, 32'h118, 32'hB00, 4'b0100, 0, 0, 0, 0, 0);
        step(4'd3, 32'h11C, 0, 0, 32'h55, 32'h55, 0, 0, 0);
        // R8: count of 1 falls through, count of 0 wraps and is taken
        step(4'd6, 32'h120, 32'hC00, 0, 1, 0, 0, 0, 0);
        step(4'd6, 32'h124, 32'hC00, 0, 0, 0, 0, 0, 0);
        // R9 and R10
        step(4'd7, 32'h128, 32'hD00, 0, 0, 0, 0, 0, 0);
        step(4'd8, 32'h12C, 0, 0, 0, 32'hE04, 0, 0, 0);
        // R11: undefined code acts as no-op, R5: code held
        step(4'd12, 32'hFFFF_FFFC, 32'h1, 4'hF, 0, 0, 1, 0, 1);
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] op;
            logic [DW-1:0] a, b;
            op = 4'($urandom_range(0, 9));
            a = ($urandom_range(0, 3) == 0) ? DW'($urandom_range(0, 3)) : DW'($urandom);
            b = ($urandom_range(0, 3) == 0) ? a : DW'($urandom);
            step(op, AW'($urandom), AW'($urandom), 4'($urandom), a, b,
                 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
        end
        // R6: jump
        step(4'd4, 32'h200, 32'h4000, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule